// File: doc/BRIEF.md
# Transceiver Loopback Calibration Sequencer

This block orders the self-calibration of a radio transceiver. The transmitter is the stimulus source and the receiver is the analyzer. Calibration runs in four fixed phases, and each phase depends on the corrections that the phases before it have stored:

1. Receive baseband filter path. The transmit baseband supplies the tone. The receive path under test includes the gain amplifier and the converter.
2. Transmit baseband filter path. The now-corrected receive baseband acts as the analyzer.
3. Transmit RF I/Q error. The signal is measured through the power detector and the receive baseband.
4. Receive RF I/Q error. The transmitter tone is fed back through an attenuator.

The gain and cut-off corrections from phases 1 and 2 and the I/Q corrections from phases 3 and 4 are held in four correction registers. The digital baseband reads these registers.

Each phase starts with a settle window. During this window the loopback path code and the tone enable are driven, but no measurement is requested. The sequencer then requests a measurement and waits for the shared engine's done pulse. It latches the engine's result word into that phase's correction register and moves on. A measurement that runs past a cycle budget ends the sequence in an error state, which reports the phase number. An abort returns the block to idle and leaves every correction register as it was.

Top module: `lbcal_seq`

## Requirements
- R1: After reset the block is idle: path code 0, tone_en_o, det_en_o, atten_en_o, meas_req_o, busy_o, done_o and err_o all low, err_phase_o 0, all four correction registers 0.
- R2: A start_i pulse seen while idle, done or in error begins phase 1 on the next cycle: busy_o high, path code 1, tone_en_o high, err_o and done_o low.
- R3: Phases run strictly in the order of path codes 1 (receive baseband loop), 2 (transmit baseband loop), 3 (transmit RF detector loop), 4 (receive RF attenuator loop). Each phase advances only on meas_done_i during its measure window.
- R4: Every phase first holds its path code and tone_en_o for exactly SETTLE_CYC cycles with meas_req_o low, then raises meas_req_o.
- R5: meas_done_i during a settle window is ignored: the phase, the window length and the correction registers are unaffected.
- R6: meas_done_i during a measure window writes meas_res_i (gain code in the upper half, phase code in the lower half) into the register of the current phase on the next cycle. The other three registers keep their values.
- R7: det_en_o is high only in phase 3 and atten_en_o only in phase 4. The two are never high together.
- R8: The done pulse of phase 4 leads, on the next cycle, to done_o high, busy_o low, path code 0 and tone_en_o low.
- R9: If meas_req_o stays high for TIMEOUT_CYC cycles with no meas_done_i, the block enters error: err_o high, err_phase_o = failing phase number (1 to 4), busy_o low, and nothing is written.
- R10: abort_i while busy returns the block to idle on the next cycle with done_o and err_o low. No correction register is written, even if meas_done_i arrives in the same cycle.
- R11: start_i while busy is ignored; the running phase and its counts continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a calibration sequence |
| abort_i | input | 1 | Return to idle without writing |
| meas_done_i | input | 1 | Measurement engine done pulse |
| meas_res_i | input | 2*RES_W | Engine result: gain code high half, phase code low half |
| path_sel_o | output | 3 | Loopback path code, 0 when inactive |
| tone_en_o | output | 1 | Transmit test-tone generator enable |
| det_en_o | output | 1 | Power detector path enable (phase 3) |
| atten_en_o | output | 1 | Feedback attenuator enable (phase 4) |
| meas_req_o | output | 1 | Measurement engine request |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | All four phases completed |
| err_o | output | 1 | Sequence stopped by timeout |
| err_phase_o | output | 3 | Phase number that timed out, 0 otherwise |
| corr_rxbb_o | output | 2*RES_W | Receive baseband correction |
| corr_txbb_o | output | 2*RES_W | Transmit baseband correction |
| corr_txrf_o | output | 2*RES_W | Transmit RF I/Q correction |
| corr_rxrf_o | output | 2*RES_W | Receive RF I/Q correction |

## Verification
A wrong phase register is visible at once on path_sel_o and on the detector and attenuator enables, and one cycle later as a result landing in the wrong correction register. A window counter that is off by one lengthens or shortens the settle window or the timeout by that amount, which shows as a miscounted cycle on meas_req_o or err_o. A write-enable fault shows on the cycle after a done pulse that should have been ignored during settle or abort. The scoreboard expects exactly the writes the driver announced, so any missing or extra write stands out.

// File: rtl/lbcal_pkg.sv
package lbcal_pkg;
  localparam int N_PH = 4;
  localparam int PH_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_MEAS, ST_DONE, ST_ERR
  } st_e;

  typedef enum logic [2:0] {
    PATH_OFF  = 3'd0,
    PATH_RXBB = 3'd1,
    PATH_TXBB = 3'd2,
    PATH_TXRF = 3'd3,
    PATH_RXRF = 3'd4
  } path_e;

  function automatic path_e path_of(input logic [PH_W-1:0] ph);
    case (ph)
      2'd0:    return PATH_RXBB;
      2'd1:    return PATH_TXBB;
      2'd2:    return PATH_TXRF;
      default: return PATH_RXRF;
    endcase
  endfunction
endpackage

// File: rtl/lbcal_timer.sv
module lbcal_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (clr_i)             cnt_o <= '0;
    else if (cnt_o != '1)       cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/lbcal_corr_bank.sv
module lbcal_corr_bank #(
  parameter int W = 16,
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [W-1:0]         wr_data_i,
  output logic [N-1:0][W-1:0]  regs_o
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_o[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))     regs_o[g] <= wr_data_i;
    end
  end

  // R6: without a write strobe every register holds
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o));
endmodule

// File: rtl/lbcal_ctrl.sv
module lbcal_ctrl
  import lbcal_pkg::*;
#(
  parameter int SETTLE_CYC  = 4,
  parameter int TIMEOUT_CYC = 64,
  parameter int CNT_W       = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             meas_done_i,
  input  logic [CNT_W-1:0] cnt_i,
  output st_e              st_o,
  output logic [PH_W-1:0]  ph_o,
  output logic             clr_o,
  output logic             wr_o,
  output logic [2:0]       err_ph_o
);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] TO_LAST     = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [PH_W-1:0]  PH_LAST     = PH_W'(N_PH - 1);

  st_e             st_n;
  logic [PH_W-1:0] ph_n;
  logic [2:0]      err_ph_n;

  always_comb begin
    st_n     = st_o;
    ph_n     = ph_o;
    err_ph_n = err_ph_o;
    clr_o    = 1'b0;
    wr_o     = 1'b0;
    unique case (st_o)
      ST_IDLE, ST_DONE, ST_ERR: begin
        clr_o = 1'b1;
        if (start_i) begin
          st_n     = ST_SETTLE;
          ph_n     = '0;
          err_ph_n = '0;
        end else if (abort_i) begin
          st_n = ST_IDLE;
        end
      end
      ST_SETTLE: begin
        if (abort_i) begin
          st_n  = ST_IDLE;
          clr_o = 1'b1;
        end else if (cnt_i == SETTLE_LAST) begin
          st_n  = ST_MEAS;
          clr_o = 1'b1;
        end
      end
      ST_MEAS: begin
        if (abort_i) begin
          st_n  = ST_IDLE;
          clr_o = 1'b1;
        end else if (meas_done_i) begin
          wr_o  = 1'b1;
          clr_o = 1'b1;
          if (ph_o == PH_LAST) st_n = ST_DONE;
          else begin
            st_n = ST_SETTLE;
            ph_n = ph_o + 1'b1;
          end
        end else if (cnt_i == TO_LAST) begin
          st_n     = ST_ERR;
          err_ph_n = 3'(ph_o) + 3'd1;
          clr_o    = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o     <= ST_IDLE;
      ph_o     <= '0;
      err_ph_o <= '0;
    end else begin
      st_o     <= st_n;
      ph_o     <= ph_n;
      err_ph_o <= err_ph_n;
    end
  end

  // R11: a start while active neither rewinds nor skips a phase
  a_r11_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_o == ST_SETTLE && !abort_i) |=> ph_o == $past(ph_o));
  // R5: done in settle never produces a write
  a_r5_settle_nowr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_o == ST_SETTLE |-> !wr_o);
endmodule

// File: rtl/lbcal_seq.sv
module lbcal_seq
  import lbcal_pkg::*;
#(
  parameter int RES_W       = 8,
  parameter int SETTLE_CYC  = 4,
  parameter int TIMEOUT_CYC = 64,
  localparam int CORR_W     = 2 * RES_W,
  localparam int MAX_WIN    = (TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC,
  localparam int CNT_W      = $clog2(MAX_WIN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              meas_done_i,
  input  logic [CORR_W-1:0] meas_res_i,
  output logic [2:0]        path_sel_o,
  output logic              tone_en_o,
  output logic              det_en_o,
  output logic              atten_en_o,
  output logic              meas_req_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2:0]        err_phase_o,
  output logic [CORR_W-1:0] corr_rxbb_o,
  output logic [CORR_W-1:0] corr_txbb_o,
  output logic [CORR_W-1:0] corr_txrf_o,
  output logic [CORR_W-1:0] corr_rxrf_o
);
  st_e                          st;
  logic [PH_W-1:0]              ph;
  logic                         clr, wr;
  logic [2:0]                   err_ph;
  logic [CNT_W-1:0]             cnt;
  logic [N_PH-1:0][CORR_W-1:0]  corr;

  lbcal_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .clr_i(clr), .cnt_o(cnt)
  );

  lbcal_ctrl #(
    .SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .abort_i, .meas_done_i,
    .cnt_i(cnt), .st_o(st), .ph_o(ph), .clr_o(clr), .wr_o(wr), .err_ph_o(err_ph)
  );

  lbcal_corr_bank #(.W(CORR_W), .N(N_PH)) u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr), .wr_idx_i(ph), .wr_data_i(meas_res_i), .regs_o(corr)
  );

  assign busy_o      = (st == ST_SETTLE) || (st == ST_MEAS);
  assign path_sel_o  = busy_o ? path_of(ph) : PATH_OFF;
  assign tone_en_o   = busy_o;  // TX is stimulus in every phase
  assign det_en_o    = busy_o && path_of(ph) == PATH_TXRF;
  assign atten_en_o  = busy_o && path_of(ph) == PATH_RXRF;
  assign meas_req_o  = st == ST_MEAS;
  assign done_o      = st == ST_DONE;
  assign err_o       = st == ST_ERR;
  assign err_phase_o = err_o ? err_ph : 3'd0;

  assign corr_rxbb_o = corr[0];
  assign corr_txbb_o = corr[1];
  assign corr_txrf_o = corr[2];
  assign corr_rxrf_o = corr[3];

  a_r2_first_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> path_sel_o == PATH_RXBB);
  a_r4_req_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_req_o |-> busy_o && tone_en_o && path_sel_o != PATH_OFF);
  a_r7_det_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_en_o |-> path_sel_o == PATH_TXRF);
  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({det_en_o, atten_en_o}));
  a_r9_err_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_phase_o != 3'd0 && !busy_o);
  a_r10_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && abort_i) |=> !busy_o && !done_o && !err_o);
  a_r8_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(meas_req_o && meas_done_i && path_sel_o == PATH_RXRF));
endmodule

// File: tb/tb_lbcal_seq.sv
module tb_lbcal_seq;
  localparam int RES_W = 8, S = 4, T = 64, CW = 2 * RES_W;

  logic clk = 0, rst_n = 0;
  logic start = 0, abort = 0, mdone = 0;
  logic [CW-1:0] mres = '0;
  logic [2:0] path, errph;
  logic tone, det, att, mreq, busy, done, err;
  logic [CW-1:0] c0, c1, c2, c3;

  always #4 clk = ~clk;  // 125 MHz

  lbcal_seq #(.RES_W(RES_W), .SETTLE_CYC(S), .TIMEOUT_CYC(T)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort),
    .meas_done_i(mdone), .meas_res_i(mres), .path_sel_o(path), .tone_en_o(tone),
    .det_en_o(det), .atten_en_o(att), .meas_req_o(mreq), .busy_o(busy),
    .done_o(done), .err_o(err), .err_phase_o(errph), .corr_rxbb_o(c0),
    .corr_txbb_o(c1), .corr_txrf_o(c2), .corr_rxrf_o(c3));

  int n_chk = 0, n_fail = 0;
  logic [CW+1:0] exp_q[$];   // {index, value}
  logic [CW-1:0] prev[4] = '{default: '0};
  logic [CW-1:0] cur[4];
  assign cur[0] = c0; assign cur[1] = c1; assign cur[2] = c2; assign cur[3] = c3;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // monitor: every register change must match the next announced write (R6)
  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < 4; i++) if (cur[i] !== prev[i]) begin
      if (exp_q.size() == 0) chk(0, "R6 unexpected write", i, 32'hffff);
      else begin
        logic [CW+1:0] e;
        e = exp_q.pop_front();
        chk(e[CW+1:CW] == 2'(i) && e[CW-1:0] == cur[i], "R6 write", {i[15:0], cur[i]}, {14'd0, e});
      end
      prev[i] = cur[i];
    end
  end

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_req();
    while (!mreq) @(negedge clk);
  endtask

  // drive done with a result during measure, announcing the expected write
  task automatic finish_phase(input int p, input logic [CW-1:0] v);
    chk(path == 3'(p + 1), "R3 phase order", path, p + 1);
    chk(det == (p == 2) && att == (p == 3), "R7 path enables", {det, att}, {p == 2, p == 3});
    exp_q.push_back({2'(p), v});
    mres = v; mdone = 1; @(negedge clk); mdone = 0;
  endtask

  task automatic to_phase(input int p, input logic [CW-1:0] base);
    for (int k = 0; k < p; k++) begin wait_req(); finish_phase(k, base + CW'(k)); end
    wait_req();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(path == 0 && !tone && !det && !att && !mreq && !busy && !done && !err && errph == 0,
        "R1 reset outputs", {path, tone, mreq, busy, done, err}, 0);
    chk({c0, c1, c2, c3} == '0, "R1 reset corrections", c0, 0);
    rst_n = 1; @(negedge clk);

    // full run
    pulse_start();
    chk(busy && path == 1 && tone && !mreq && !done && !err, "R2 start", {busy, path, tone, mreq}, {1'b1, 3'd1, 1'b1, 1'b0});
    begin
      int cnt = 0;
      while (!mreq) begin
        if (busy) cnt++;
        if (cnt == 2) begin mdone = 1; mres = 16'hdead; start = 1; end
        else begin mdone = 0; start = 0; end
        @(negedge clk);
      end
      mdone = 0; start = 0;
      chk(cnt == S, "R4 settle length", cnt, S);
      chk(c0 == 0, "R5 done in settle ignored", c0, 0);
      chk(path == 1, "R11 start while busy ignored", path, 1);
    end
    finish_phase(0, 16'h11a0);
    chk(!mreq && busy && path == 2, "R3 next phase settles", {mreq, path}, 2);
    for (int p = 1; p < 4; p++) begin wait_req(); finish_phase(p, 16'h11a0 + CW'(p)); end
    chk(done && !busy && path == 0 && !tone, "R8 sequence done", {done, busy, path, tone}, {1'b1, 1'b0, 3'd0, 1'b0});

    // timeout in phase 2
    pulse_start();
    chk(!done && busy && path == 1, "R2 restart from done", {done, busy, path}, 1);
    to_phase(1, 16'h2200);
    begin
      int cnt = 0;
      while (!err) begin if (mreq) cnt++; @(negedge clk); end
      chk(cnt == T, "R9 timeout length", cnt, T);
    end
    chk(errph == 2 && !busy, "R9 error phase 2", errph, 2);
    chk(c1 == 16'h11a1, "R9 no write on timeout", c1, 16'h11a1);

    // abort with a coincident done in phase 3
    pulse_start();
    chk(!err && busy && path == 1, "R2 restart from error", {err, path}, 1);
    to_phase(2, 16'h3300);
    abort = 1; mdone = 1; mres = 16'hbeef; @(negedge clk); abort = 0; mdone = 0;
    chk(!busy && !done && !err && path == 0, "R10 abort to idle", {busy, done, err}, 0);
    repeat (2) @(negedge clk);
    chk(c2 == 16'h11a2, "R10 correction kept", c2, 16'h11a2);

    // abort during settle
    pulse_start(); @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    chk(!busy && path == 0, "R10 abort in settle", busy, 0);

    // timeout in phase 4
    pulse_start();
    to_phase(3, 16'h4400);
    chk(att && !det && path == 4, "R7 attenuator in phase 4", {att, det}, 2'b10);
    while (!err) @(negedge clk);
    chk(errph == 4, "R9 error phase 4", errph, 4);
    chk(c3 == 16'h11a3, "R9 phase 4 kept", c3, 16'h11a3);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all writes seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule